// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block picks the two source operands of the execute stage in a seven-stage in-order integer pipeline. The stages run fetch-1, fetch-2, decode, execute, memory-1, memory-2 and writeback. Three instructions are still in flight ahead of execute and have not yet written the register file. Each source index is matched against the destinations of those three instructions, and the newest matching result is routed to execute. A consumer can therefore follow its producer in the very next slot. Without bypassing it would need three padding no-ops in between.

Data memory takes two stages, because read data is returned one or two clocks after the address. A load's result therefore cannot be bypassed until the load reaches writeback. When an execute operand depends on a load that is still in memory-1 or memory-2, the unit raises a stall request. The pipeline control holds execute until the load moves on. The register file, the ALU and branch resolution sit outside this block. Their values reach it as plain inputs, and all results are combinational.

Top module: `op_bypass_unit`

## Requirements
- R1: When no valid writing stage has a destination equal to a source index, that operand's select is 2'b00 and its data equals the register-file value.
- R2: A match in memory-1 gives select 2'b01 and the memory-1 result.
- R3: A match in memory-2 only gives select 2'b10 and the memory-2 result.
- R4: A match in writeback only gives select 2'b11 and the writeback result.
- R5: When several stages match, the youngest one is chosen, in the order memory-1, then memory-2, then writeback.
- R6: Source index 0 always gives select 2'b00 and operand value 0. This holds even when the register-file input or a stage writing register 0 carries a nonzero value.
- R7: A stage with its valid bit low, or with its write-enable low, never matches.
- R8: The two operands are resolved independently. Each can take a different source in the same cycle.
- R9: The stall output is 1 when execute is valid and a used operand's youngest match is a load in memory-1 or memory-2.
- R10: A load result matched in writeback is forwarded with select 2'b11 and causes no stall. A non-load match in memory-1 that is younger than a load match in memory-2 also causes no stall.
- R11: The stall output is 0 when execute is not valid, or when the only load dependence is on an operand whose use flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the bound checker |
| rst_n | input | 1 | Active-low reset, used only by the bound checker |
| ex_valid | input | 1 | Execute slot holds a real instruction |
| ex_rs1_idx | input | 5 | First source register index |
| ex_rs1_use | input | 1 | First source is read by the instruction |
| ex_rs2_idx | input | 5 | Second source register index |
| ex_rs2_use | input | 1 | Second source is read by the instruction |
| rf_rs1_data | input | 32 | Register-file value for the first source |
| rf_rs2_data | input | 32 | Register-file value for the second source |
| m1_valid | input | 1 | Memory-1 slot holds a real instruction |
| m1_wen | input | 1 | Memory-1 instruction writes a register |
| m1_load | input | 1 | Memory-1 instruction is a load |
| m1_rd | input | 5 | Memory-1 destination index |
| m1_data | input | 32 | Memory-1 result |
| m2_valid | input | 1 | Memory-2 slot holds a real instruction |
| m2_wen | input | 1 | Memory-2 instruction writes a register |
| m2_load | input | 1 | Memory-2 instruction is a load |
| m2_rd | input | 5 | Memory-2 destination index |
| m2_data | input | 32 | Memory-2 result |
| wb_valid | input | 1 | Writeback slot holds a real instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| wb_rd | input | 5 | Writeback destination index |
| wb_data | input | 32 | Writeback result, including load data |
| op1_sel | output | 2 | First operand source: 00 rf, 01 m1, 10 m2, 11 wb |
| op1_data | output | 32 | First operand value |
| op2_sel | output | 2 | Second operand source, same encoding |
| op2_data | output | 32 | Second operand value |
| ld_stall | output | 1 | Hold execute for an unready load result |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus, with no register delay. The bench changes inputs just after a falling clock edge. It samples one nanosecond later, well before the next rising edge. Each sample therefore reflects only the pattern just applied. The bound properties check the same relations at every rising edge.

// File: rtl/op_bypass_pkg.sv
package op_bypass_pkg;
  localparam int REG_AW = 5;
  localparam int NSTG   = 3;   // memory-1, memory-2, writeback (youngest first)

  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_M1 = 2'b01,
    SEL_M2 = 2'b10,
    SEL_WB = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic              vld;
    logic              wen;
    logic              ld;
    logic [REG_AW-1:0] rd;
  } stg_tag_t;
endpackage

// File: rtl/byp_match.sv
module byp_match
  import op_bypass_pkg::*;
#(
  parameter int N = NSTG
) (
  input  logic [REG_AW-1:0] idx,
  input  stg_tag_t          tag [N],
  output logic [N-1:0]      hit
);
  logic idx_nz;
  assign idx_nz = (idx != '0);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = idx_nz & tag[g].vld & tag[g].wen & (tag[g].rd == idx);
  end
endmodule

// File: rtl/byp_pick.sv
module byp_pick
  import op_bypass_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int N    = NSTG
) (
  input  logic [N-1:0]    hit,
  input  logic [N-1:0]    ld,
  input  logic [XLEN-1:0] stg_dat [N],
  input  logic [XLEN-1:0] rf_dat,
  input  logic            idx_zero,
  output src_sel_e        sel,
  output logic [XLEN-1:0] dat,
  output logic            ld_pend
);
  // stages whose load data is not yet returned by memory
  localparam logic [N-1:0] LD_EARLY = {{(N-2){1'b0}}, 2'b11};

  always_comb begin
    sel     = SEL_RF;
    dat     = idx_zero ? '0 : rf_dat;
    ld_pend = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel     = src_sel_e'(2'(i + 1));
        dat     = stg_dat[i];
        ld_pend = ld[i] & LD_EARLY[i];
      end
    end
  end
endmodule

// File: rtl/byp_hazard.sv
module byp_hazard #(
  parameter int NSRC = 2
) (
  input  logic            ex_valid,
  input  logic [NSRC-1:0] src_use,
  input  logic [NSRC-1:0] src_pend,
  output logic            stall
);
  assign stall = ex_valid & |(src_use & src_pend);
endmodule

// File: rtl/op_bypass_unit.sv
module op_bypass_unit
  import op_bypass_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_valid,
  input  logic [REG_AW-1:0] ex_rs1_idx,
  input  logic              ex_rs1_use,
  input  logic [REG_AW-1:0] ex_rs2_idx,
  input  logic              ex_rs2_use,
  input  logic [XLEN-1:0]   rf_rs1_data,
  input  logic [XLEN-1:0]   rf_rs2_data,
  input  logic              m1_valid,
  input  logic              m1_wen,
  input  logic              m1_load,
  input  logic [REG_AW-1:0] m1_rd,
  input  logic [XLEN-1:0]   m1_data,
  input  logic              m2_valid,
  input  logic              m2_wen,
  input  logic              m2_load,
  input  logic [REG_AW-1:0] m2_rd,
  input  logic [XLEN-1:0]   m2_data,
  input  logic              wb_valid,
  input  logic              wb_wen,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic [XLEN-1:0]   wb_data,
  output logic [1:0]        op1_sel,
  output logic [XLEN-1:0]   op1_data,
  output logic [1:0]        op2_sel,
  output logic [XLEN-1:0]   op2_data,
  output logic              ld_stall
);
  localparam int NSRC = 2;

  stg_tag_t          tag [NSTG];
  logic [XLEN-1:0]   sdat [NSTG];
  logic [NSTG-1:0]   sld;

  assign tag[0]  = '{vld: m1_valid, wen: m1_wen, ld: m1_load, rd: m1_rd};
  assign tag[1]  = '{vld: m2_valid, wen: m2_wen, ld: m2_load, rd: m2_rd};
  assign tag[2]  = '{vld: wb_valid, wen: wb_wen, ld: 1'b0,    rd: wb_rd};
  assign sdat[0] = m1_data;
  assign sdat[1] = m2_data;
  assign sdat[2] = wb_data;

  for (genvar t = 0; t < NSTG; t++) begin : g_ld
    assign sld[t] = tag[t].ld;
  end

  logic [REG_AW-1:0] src_idx [NSRC];
  logic [XLEN-1:0]   src_rf  [NSRC];
  src_sel_e          src_sel [NSRC];
  logic [XLEN-1:0]   src_dat [NSRC];
  logic [NSRC-1:0]   src_pend;
  logic [NSRC-1:0]   src_use;

  assign src_idx[0] = ex_rs1_idx;
  assign src_idx[1] = ex_rs2_idx;
  assign src_rf[0]  = rf_rs1_data;
  assign src_rf[1]  = rf_rs2_data;
  assign src_use    = {ex_rs2_use, ex_rs1_use};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [NSTG-1:0] hit;

    byp_match #(.N(NSTG)) u_match (
      .idx (src_idx[s]),
      .tag (tag),
      .hit (hit)
    );

    byp_pick #(.XLEN(XLEN), .N(NSTG)) u_pick (
      .hit      (hit),
      .ld       (sld),
      .stg_dat  (sdat),
      .rf_dat   (src_rf[s]),
      .idx_zero (src_idx[s] == '0),
      .sel      (src_sel[s]),
      .dat      (src_dat[s]),
      .ld_pend  (src_pend[s])
    );
  end

  byp_hazard #(.NSRC(NSRC)) u_haz (
    .ex_valid (ex_valid),
    .src_use  (src_use),
    .src_pend (src_pend),
    .stall    (ld_stall)
  );

  assign op1_sel  = src_sel[0];
  assign op1_data = src_dat[0];
  assign op2_sel  = src_sel[1];
  assign op2_data = src_dat[1];
endmodule

// File: rtl/op_bypass_chk.sv
module op_bypass_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ex_valid,
  input logic [4:0]  ex_rs1_idx,
  input logic [4:0]  ex_rs2_idx,
  input logic        m1_valid,
  input logic        m1_wen,
  input logic        m1_load,
  input logic [4:0]  m1_rd,
  input logic        m2_valid,
  input logic        m2_load,
  input logic [31:0] wb_data,
  input logic [1:0]  op1_sel,
  input logic [31:0] op1_data,
  input logic [1:0]  op2_sel,
  input logic [31:0] op2_data,
  input logic        ld_stall
);
  p_zero_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1_idx == 5'd0) |-> (op1_sel == 2'b00 && op1_data == 32'd0));

  p_m1_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_valid && m1_wen && m1_rd == ex_rs2_idx && ex_rs2_idx != 5'd0) |-> (op2_sel == 2'b01));

  p_no_idle_m1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1_valid || !m1_wen) |-> (op1_sel != 2'b01 && op2_sel != 2'b01));

  p_wb_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op1_sel == 2'b11) |-> (op1_data == wb_data));

  p_idle_nostall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |-> !ld_stall);

  p_stall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> ((m1_valid && m1_load) || (m2_valid && m2_load)));
endmodule

bind op_bypass_unit op_bypass_chk u_chk (.*);

// File: tb/tb_op_bypass_unit.sv
module tb_op_bypass_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        ex_valid, ex_rs1_use, ex_rs2_use;
  logic [4:0]  ex_rs1_idx, ex_rs2_idx;
  logic [31:0] rf_rs1_data, rf_rs2_data;
  logic        m1_valid, m1_wen, m1_load, m2_valid, m2_wen, m2_load, wb_valid, wb_wen;
  logic [4:0]  m1_rd, m2_rd, wb_rd;
  logic [31:0] m1_data, m2_data, wb_data;
  logic [1:0]  op1_sel, op2_sel;
  logic [31:0] op1_data, op2_data;
  logic        ld_stall;

  int n_run = 0;
  int n_fail = 0;

  op_bypass_unit dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    ex_valid = 1'b1; ex_rs1_use = 1'b1; ex_rs2_use = 1'b1;
    ex_rs1_idx = 5'd1; ex_rs2_idx = 5'd2;
    rf_rs1_data = 32'h1111_0001; rf_rs2_data = 32'h2222_0002;
    {m1_valid, m1_wen, m1_load} = 3'b000; m1_rd = 5'd0; m1_data = 32'hA1A1_A1A1;
    {m2_valid, m2_wen, m2_load} = 3'b000; m2_rd = 5'd0; m2_data = 32'hB2B2_B2B2;
    {wb_valid, wb_wen} = 2'b00; wb_rd = 5'd0; wb_data = 32'hC3C3_C3C3;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_rf_path();
    clear_all(); settle();
    chk("R1 sel1", op1_sel, 2'b00);  chk("R1 data1", op1_data, 32'h1111_0001);
    chk("R1 sel2", op2_sel, 2'b00);  chk("R1 data2", op2_data, 32'h2222_0002);
    chk("R1 stall", ld_stall, 1'b0);
  endtask

  task automatic t_single_stage();
    clear_all(); m1_valid = 1; m1_wen = 1; m1_rd = 5'd1; settle();
    chk("R2 sel", op1_sel, 2'b01); chk("R2 data", op1_data, 32'hA1A1_A1A1);
    clear_all(); m2_valid = 1; m2_wen = 1; m2_rd = 5'd1; settle();
    chk("R3 sel", op1_sel, 2'b10); chk("R3 data", op1_data, 32'hB2B2_B2B2);
    clear_all(); wb_valid = 1; wb_wen = 1; wb_rd = 5'd2; settle();
    chk("R4 sel", op2_sel, 2'b11); chk("R4 data", op2_data, 32'hC3C3_C3C3);
  endtask

  task automatic t_priority();
    clear_all();
    m1_valid = 1; m1_wen = 1; m1_rd = 5'd1;
    m2_valid = 1; m2_wen = 1; m2_rd = 5'd1;
    wb_valid = 1; wb_wen = 1; wb_rd = 5'd1; settle();
    chk("R5 all three", op1_sel, 2'b01); chk("R5 all data", op1_data, 32'hA1A1_A1A1);
    @(negedge clk); m1_rd = 5'd9; settle();
    chk("R5 m2 over wb", op1_sel, 2'b10); chk("R5 m2 data", op1_data, 32'hB2B2_B2B2);
  endtask

  task automatic t_zero_reg();
    clear_all(); ex_rs1_idx = 5'd0; rf_rs1_data = 32'hDEAD_BEEF;
    m1_valid = 1; m1_wen = 1; m1_rd = 5'd0;
    wb_valid = 1; wb_wen = 1; wb_rd = 5'd0; settle();
    chk("R6 sel", op1_sel, 2'b00); chk("R6 data", op1_data, 32'h0);
  endtask

  task automatic t_invalid();
    clear_all(); m1_valid = 0; m1_wen = 1; m1_rd = 5'd1;
    m2_valid = 1; m2_wen = 0; m2_rd = 5'd1; settle();
    chk("R7 sel", op1_sel, 2'b00); chk("R7 data", op1_data, 32'h1111_0001);
    @(negedge clk); wb_valid = 0; wb_wen = 1; wb_rd = 5'd1; settle();
    chk("R7 wb invalid", op1_sel, 2'b00);
  endtask

  task automatic t_independent();
    clear_all(); m2_valid = 1; m2_wen = 1; m2_rd = 5'd1;
    wb_valid = 1; wb_wen = 1; wb_rd = 5'd2; settle();
    chk("R8 op1 sel", op1_sel, 2'b10); chk("R8 op2 sel", op2_sel, 2'b11);
    chk("R8 op2 data", op2_data, 32'hC3C3_C3C3);
  endtask

  task automatic t_load_stall();
    clear_all(); m1_valid = 1; m1_wen = 1; m1_load = 1; m1_rd = 5'd2; settle();
    chk("R9 m1 load", ld_stall, 1'b1);
    clear_all(); m2_valid = 1; m2_wen = 1; m2_load = 1; m2_rd = 5'd1; settle();
    chk("R9 m2 load", ld_stall, 1'b1);
  endtask

  task automatic t_load_ready();
    clear_all(); wb_valid = 1; wb_wen = 1; wb_rd = 5'd1; settle();
    chk("R10 wb load stall", ld_stall, 1'b0); chk("R10 wb load sel", op1_sel, 2'b11);
    clear_all(); m2_valid = 1; m2_wen = 1; m2_load = 1; m2_rd = 5'd1;
    m1_valid = 1; m1_wen = 1; m1_load = 0; m1_rd = 5'd1; settle();
    chk("R10 younger alu", ld_stall, 1'b0); chk("R10 younger sel", op1_sel, 2'b01);
  endtask

  task automatic t_stall_gate();
    clear_all(); m1_valid = 1; m1_wen = 1; m1_load = 1; m1_rd = 5'd1; ex_valid = 0; settle();
    chk("R11 ex idle", ld_stall, 1'b0);
    @(negedge clk); ex_valid = 1; ex_rs1_use = 0; settle();
    chk("R11 unused src", ld_stall, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_rf_path();
    t_single_stage();
    t_priority();
    t_zero_reg();
    t_invalid();
    t_independent();
    t_load_stall();
    t_load_ready();
    t_stall_gate();
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule